// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer and Serial Output

This block is the digital half of a 12-bit successive-approximation converter. A rising edge on the start input puts the external track-and-hold into hold. It then runs a binary search. The current trial code is presented to the external DAC, and one comparator decision is taken per bit interval, from the most significant bit down to the least. The bit interval is a fixed number of system clocks. At the end of the search the result is latched and the hold indication returns to track. No end-of-conversion flag leaves the block.

The result leaves through a two-wire serial port: a serial clock driven from outside and a data line driven by the block. Both the start input and the serial clock are asynchronous to the system clock and are synchronised inside. A finished result normally refreshes the output word at once. If a read is under way, the refresh waits until that read completes. If the read is still unfinished when the start input next falls, the refresh is forced at that falling edge and the bit counter restarts.

Top module: `sar_core`

## Requirements
- R1: While rst_ni is low and after its release, sdata_o and hold_o are 0 and trial_o is all zeros.
- R2: A rising edge of conv_start_i sets hold_o to 1. The first trial code presented is the MSB alone (12'h800 at the default width).
- R3: hold_o stays 1 for exactly RES_W*CYC_PER_BIT clock cycles and then returns to 0. Each decision keeps the bit under test when cmp_i is 1 (the analog input is at or above trial_o) and clears it when cmp_i is 0, so the result equals the input code.
- R4: A rising edge of conv_start_i while hold_o is 1 is ignored: it does not shorten, lengthen or restart the conversion or alter its result.
- R5: With no read in progress, the result is loaded into the output word when the conversion ends. A read shifts it out MSB first, one new bit after each rising edge of sclk_i.
- R6: A read is in progress from its first sclk_i rising edge until the sclk_i falling edge that follows the twelfth rising edge. A conversion ending during a read leaves that read returning the old word in full. The new result is loaded when the read completes.
- R7: If a postponed load is still pending at a falling edge of conv_start_i, the output word is loaded at that edge, the bit count returns to zero and sdata_o goes to 0. The next read starts again from the MSB of the new word.
- R8: sdata_o is 0 whenever no read is in progress, including after the twelfth bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; CYC_PER_BIT cycles make one bit interval |
| rst_ni | input | 1 | Asynchronous active-low reset |
| conv_start_i | input | 1 | Conversion start; rising edge starts, falling edge may force a pending load |
| cmp_i | input | 1 | Comparator result, 1 when the analog input is at or above trial_o |
| sclk_i | input | 1 | Serial clock from the reader |
| trial_o | output | RES_W | Trial code for the external DAC |
| hold_o | output | 1 | 1 = hold, 0 = track |
| sdata_o | output | 1 | Serial data, MSB first, updated after sclk_i rising edges |

## Verification
A corrupted trial or bit index shows as a wrong word on the very next read. A miscounted divider shows as a hold interval that differs from 96 clocks, visible as soon as hold_o falls. A pending flag that is set or cleared wrongly shows as a read returning a mix of the old and new words across the end of conversion. It can also show as the new word missing from the read after a forced load. A stuck bit counter shows as sdata_o not returning low after the twelfth bit, or a later read not starting from the MSB.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned DEF_RES_W   = 12;
  localparam int unsigned DEF_CYC_BIT = 8;

  typedef enum logic {
    SEQ_TRACK = 1'b0,
    SEQ_CONV  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/sar_sync_edge.sv
module sar_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned W   = DEF_RES_W,
  parameter int unsigned CPB = DEF_CYC_BIT
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_rise_i,
  input  logic         cmp_i,
  output logic         hold_o,
  output logic [W-1:0] trial_o,
  output logic [W-1:0] result_o,
  output logic         done_o
);
  localparam int unsigned DIV_W = (CPB > 1) ? $clog2(CPB) : 1;
  localparam int unsigned IDX_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CPB - 1);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  seq_state_e       state_q;
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] idx_q;
  logic [W-1:0]     trial_q, result_q;
  logic             done_q;
  logic [W-1:0]     cur_mask, decided;

  always_comb begin
    cur_mask = ONE << idx_q;
    decided  = cmp_i ? trial_q : (trial_q & ~cur_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_TRACK;
      div_q    <= '0;
      idx_q    <= '0;
      trial_q  <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_TRACK: begin
          if (start_rise_i) begin
            state_q <= SEQ_CONV;
            div_q   <= '0;
            idx_q   <= IDX_W'(W - 1);
            trial_q <= ONE << (W - 1);
          end
        end
        SEQ_CONV: begin
          if (div_q == DIV_LAST) begin
            div_q <= '0;
            if (idx_q == '0) begin
              trial_q  <= decided;
              result_q <= decided;
              done_q   <= 1'b1;
              state_q  <= SEQ_TRACK;
            end else begin
              trial_q <= decided | (cur_mask >> 1);
              idx_q   <= idx_q - 1'b1;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: state_q <= SEQ_TRACK;
      endcase
    end
  end

  assign hold_o   = (state_q == SEQ_CONV);
  assign trial_o  = trial_q;
  assign result_o = result_q;
  assign done_o   = done_q;

  // R2: search opens on the MSB alone
  a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> trial_o == (ONE << (W - 1)));

  // R3: a result strobe always closes a hold interval
  a_r3_done_ends_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!hold_o && $past(hold_o)));

  // R3: one decision step changes at most two trial bits
  a_r3_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && $past(hold_o)) |-> $countones(trial_o ^ $past(trial_o)) <= 2);
endmodule

// File: rtl/sar_shift.sv
module sar_shift #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         start_fall_i,
  input  logic         done_i,
  input  logic [W-1:0] result_i,
  output logic         sdata_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

  logic [W-1:0]     out_q, shifted;
  logic [CNT_W-1:0] cnt_q;
  logic             active_q, pend_q, sdata_q;
  logic             finish, force_ld;

  assign shifted  = out_q << cnt_q;
  assign finish   = active_q && sclk_fall_i && (cnt_q == CNT_FULL);
  assign force_ld = start_fall_i && pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q    <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      sdata_q  <= 1'b0;
    end else if (force_ld) begin
      out_q    <= result_i;
      pend_q   <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
      sdata_q  <= 1'b0;
    end else begin
      if (finish) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
        sdata_q  <= 1'b0;
      end else if (sclk_rise_i && (cnt_q < CNT_FULL)) begin
        active_q <= 1'b1;
        sdata_q  <= shifted[W-1];
        cnt_q    <= cnt_q + 1'b1;
      end
      if (done_i) begin
        if (!active_q || finish) out_q  <= result_i;
        else                     pend_q <= 1'b1;
      end else if (finish && pend_q) begin
        out_q  <= result_i;
        pend_q <= 1'b0;
      end
    end
  end

  assign sdata_o = sdata_q;

  // R6: word is frozen while a read runs
  a_r6_defer_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !finish && !force_ld) |=> $stable(out_q));

  // R7: forced load clears count and pending flag
  a_r7_force_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_ld |=> (cnt_q == '0 && !pend_q && !sdata_o));

  // R8: line low outside a read
  a_r8_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_q |-> !sdata_o);

  // R6: count never passes the word length
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int unsigned RES_W       = DEF_RES_W,
  parameter int unsigned CYC_PER_BIT = DEF_CYC_BIT,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             conv_start_i,
  input  logic             cmp_i,
  input  logic             sclk_i,
  output logic [RES_W-1:0] trial_o,
  output logic             hold_o,
  output logic             sdata_o
);
  logic             start_rise, start_fall, sclk_rise, sclk_fall;
  logic             done;
  logic [RES_W-1:0] result;

  sar_sync_edge #(.STAGES(SYNC_STAGES)) u_start_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(conv_start_i),
    .rise_o(start_rise), .fall_o(start_fall)
  );

  sar_sync_edge #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i),
    .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  sar_seq #(.W(RES_W), .CPB(CYC_PER_BIT)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_rise_i(start_rise), .cmp_i(cmp_i),
    .hold_o(hold_o), .trial_o(trial_o), .result_o(result), .done_o(done)
  );

  sar_shift #(.W(RES_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .start_fall_i(start_fall), .done_i(done), .result_i(result), .sdata_o(sdata_o)
  );
endmodule

// File: tb/sar_core_tb.sv
module sar_core_tb;
  localparam int CPB = 8;
  localparam int HOLD_CYC = 12 * CPB;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic conv_start = 1'b0;
  logic sclk = 1'b0;
  logic [11:0] vin = '0;
  logic [11:0] trial;
  logic hold, sdata, cmp;
  int n_chk = 0;
  int n_bad = 0;
  logic [11:0] exp_out = '0;

  always #5 clk = ~clk;
  assign cmp = (trial <= vin);

  sar_core #(.RES_W(12), .CYC_PER_BIT(CPB)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .conv_start_i(conv_start), .cmp_i(cmp),
    .sclk_i(sclk), .trial_o(trial), .hold_o(hold), .sdata_o(sdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic shift_bits(input int n, inout logic [11:0] got);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk = 1'b1;
      repeat (5) @(negedge clk);
      got = {got[10:0], sdata};
      sclk = 1'b0;
      repeat (5) @(negedge clk);
    end
  endtask

  task automatic begin_conv(input logic [11:0] v);
    int guard;
    vin = v;
    @(negedge clk) conv_start = 1'b1;
    guard = 0;
    while (!hold && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    check("R2 trial MSB first", {20'd0, trial}, 32'h800);
    conv_start = 1'b0;
  endtask

  task automatic wait_conv_end();
    while (hold) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 sdata in reset", {31'd0, sdata}, 0);
    check("R1 hold in reset", {31'd0, hold}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 trial after reset", {20'd0, trial}, 0);
    check("R1 hold after reset", {31'd0, hold}, 0);
  endtask

  task automatic t_plain(input logic [11:0] v);
    int dur;
    logic [11:0] got;
    begin_conv(v);
    check("R2 hold high", {31'd0, hold}, 1);
    dur = 1;
    forever begin
      @(negedge clk);
      if (!hold) break;
      dur++;
    end
    check("R3 hold duration", dur, HOLD_CYC);
    repeat (2) @(negedge clk);
    exp_out = v;
    got = '0;
    shift_bits(12, got);
    check("R5 read word", {20'd0, got}, {20'd0, v});
    check("R8 idle low after 12th bit", {31'd0, sdata}, 0);
  endtask

  task automatic t_retrigger(input logic [11:0] v);
    int dur;
    logic [11:0] got;
    begin_conv(v);
    dur = 1;
    repeat (30) begin
      @(negedge clk);
      dur++;
    end
    conv_start = 1'b1;
    repeat (6) begin
      @(negedge clk);
      dur++;
    end
    conv_start = 1'b0;
    forever begin
      @(negedge clk);
      if (!hold) break;
      dur++;
    end
    check("R4 hold duration with retrigger", dur, HOLD_CYC);
    repeat (2) @(negedge clk);
    exp_out = v;
    got = '0;
    shift_bits(12, got);
    check("R4 result unchanged by retrigger", {20'd0, got}, {20'd0, v});
  endtask

  task automatic t_deferred(input logic [11:0] v);
    logic [11:0] got;
    logic [11:0] old_w;
    old_w = exp_out;
    begin_conv(v);
    repeat (4) @(negedge clk);
    got = '0;
    shift_bits(3, got);
    wait_conv_end();
    shift_bits(9, got);
    check("R6 read across end returns old word", {20'd0, got}, {20'd0, old_w});
    check("R8 low after read", {31'd0, sdata}, 0);
    exp_out = v;
    got = '0;
    shift_bits(12, got);
    check("R6 new word after read completes", {20'd0, got}, {20'd0, v});
  endtask

  task automatic t_forced(input logic [11:0] c, input logic [11:0] d);
    logic [11:0] got;
    begin_conv(c);
    repeat (4) @(negedge clk);
    got = '0;
    shift_bits(3, got);
    check("R6 partial read of old word", {29'd0, got[2:0]}, {29'd0, exp_out[11:9]});
    wait_conv_end();
    begin_conv(d);
    repeat (6) @(negedge clk);
    check("R7 line low after forced load", {31'd0, sdata}, 0);
    check("R7 still converting", {31'd0, hold}, 1);
    got = '0;
    shift_bits(12, got);
    check("R7 forced word read from MSB", {20'd0, got}, {20'd0, c});
    wait_conv_end();
    got = '0;
    shift_bits(12, got);
    check("R6 later word after deferred load", {20'd0, got}, {20'd0, d});
    exp_out = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_plain(12'h000);
    t_plain(12'hFFF);
    t_plain(12'h800);
    t_plain(12'h555);
    t_plain(12'h7FF);
    t_retrigger(12'hA3C);
    t_deferred(12'h1E7);
    t_forced(12'hC81, 12'h36A);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule